// File: doc/BRIEF.md
# Three-Level Forward-Mapped Page Walker

This block turns a 64-bit virtual address into a physical frame number. Two steps do the work. First it reads the top two address bits to pick one of three segments. A kernel segment address maps straight to physical memory and needs no table lookup. A user segment address is resolved through a three-level forward-mapped table, and each table fills exactly one page.

For a user address, the walker reads one entry per level over a simple read port. The first read uses the table base frame supplied on an input. Each later read uses the frame held in the entry returned by the level above. The leaf entry's valid bit and its four access enables decide whether the access is granted. The result is either a frame number or a fault code.

One walk runs at a time. A busy output tells the requester when it may issue the next lookup.

Top module: `xlate_walker`

## Requirements
- R1: The segment is chosen from VA bits 63:62. Bit 63 = 0 selects the user code/heap segment, 11 selects the user stack segment, and 10 selects the kernel direct segment. Both user segments are resolved through the same table.
- R2: A kernel direct-segment address is answered without any memory read. In kernel mode the result is fault 0 with frame = VA[44:13]. In user mode the result is fault 3 (privilege) with frame 0.
- R3: An address fault (code 1) is returned with frame 0 and no memory read in three cases:
  - a code/heap address with any of bits 62:43 set;
  - a stack address with any of bits 61:43 set;
  - a kernel direct address with any of bits 61:45 set.
- R4: A walk reads at most three 8-byte entries, strictly one level after another. Each entry's byte address is frame × 8192 + index × 8.
  - The level indices are VA[42:33], then VA[32:23], then VA[22:13].
  - The level-one frame is the table base input.
  - Each lower level uses the frame from the entry read above it.
- R5: Entry format:
  - bit 0: valid;
  - bit 1: kernel read enable;
  - bit 2: kernel write enable;
  - bit 3: user read enable;
  - bit 4: user write enable;
  - bits 63:32: frame number.
  All other bits are ignored.
- R6: An invalid entry at level one or level two ends the walk at once with fault 2 (not present). No further read is made.
- R7: An invalid leaf entry gives fault 2.
- R8: A user-mode access to a valid leaf that has neither user enable set gives fault 3 (privilege).
- R9: Otherwise the leaf is checked against the access type:
  - user write needs bit 4;
  - user read needs bit 3;
  - kernel write needs bit 2;
  - kernel read needs bit 1.
  A granted access returns fault 0 with the leaf frame. A denied one returns fault 4 (permission) with frame 0.
- R10: A request is taken only when `req_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance through the response cycle. Requests raised while busy are ignored. `mem_req` is a one-cycle pulse per entry read.
- R11: After reset, `busy`, `resp_valid` and `mem_req` are low. `resp_valid` is a one-cycle pulse, followed by a cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address to resolve |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel-mode access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| tbl_base_pfn | input | 32 | Frame number of the level-one table |
| busy | output | 1 | A lookup is in progress; new requests are ignored |
| resp_valid | output | 1 | Result pulse |
| resp_pfn | output | 32 | Resolved frame number (0 on a fault) |
| resp_fault | output | 3 | 0 none, 1 address, 2 not present, 3 privilege, 4 permission |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 45 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |

## Verification
The assertions check four rules on every cycle:
- the one-cycle read and result pulses;
- that busy covers the response;
- that direct and malformed addresses complete with zero reads;
- that no walk makes more than three reads, and every granted or permission-checked leaf comes after exactly three.

Only the bench scenarios can show behaviour that depends on table contents. This includes:
- the entry address chain computed from the returned frames;
- where a walk stops on an invalid entry;
- the frame value delivered;
- the choice between the privilege and permission faults for each enable combination;
- that a request held high during a walk does not alter it.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [2:0] {
    XF_NONE   = 3'd0,
    XF_ADDR   = 3'd1,
    XF_ABSENT = 3'd2,
    XF_PRIV   = 3'd3,
    XF_PERM   = 3'd4
  } xw_fault_e;

  typedef enum logic [1:0] {
    SEG_UCODE   = 2'd0,
    SEG_USTACK  = 2'd1,
    SEG_KDIRECT = 2'd2
  } xw_seg_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_ISSUE  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DONE   = 3'd4
  } xw_state_e;

  // Low five entry bits, valid in bit 0
  typedef struct packed {
    logic uw;
    logic ur;
    logic kw;
    logic kr;
    logic v;
  } xw_perm_t;

  localparam int PTE_FLAG_W  = 5;
  localparam int PTE_PFN_LSB = 32;

  // Access check on a valid leaf, kept separate so it can be restated
  function automatic xw_fault_e leaf_verdict(input xw_perm_t p, input logic user,
                                             input logic write);
    logic grant;
    if (!p.v) return XF_ABSENT;
    if (user && !(p.ur || p.uw)) return XF_PRIV;
    if (user) grant = write ? p.uw : p.ur;
    else      grant = write ? p.kw : p.kr;
    return grant ? XF_NONE : XF_PERM;
  endfunction

endpackage

// File: rtl/xw_seg_decode.sv
module xw_seg_decode
  import xw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LEVELS = 3,
  parameter int PFN_W  = 32
) (
  input  logic [VA_W-1:0]         va,
  input  logic                    user,
  output xw_seg_e                 seg,
  output logic                    direct,
  output xw_fault_e               early_fault,
  output logic [PFN_W-1:0]        direct_pfn,
  output logic [LEVELS*IDX_W-1:0] idx_flat
);

  localparam int USED_W = OFF_W + LEVELS * IDX_W;
  localparam int DIR_W  = OFF_W + PFN_W;

  // True when every bit of a in [lo, hi] is zero
  function automatic logic span_clear(input logic [VA_W-1:0] a, input int lo, input int hi);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < VA_W; i++) begin
      if (i >= lo && i <= hi && a[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  logic span_ok;

  always_comb begin
    if (!va[VA_W-1])     seg = SEG_UCODE;
    else if (va[VA_W-2]) seg = SEG_USTACK;
    else                 seg = SEG_KDIRECT;
  end

  always_comb begin
    case (seg)
      SEG_UCODE:  span_ok = span_clear(va, USED_W, VA_W - 2);
      SEG_USTACK: span_ok = span_clear(va, USED_W, VA_W - 3);
      default:    span_ok = span_clear(va, DIR_W, VA_W - 3);
    endcase
  end

  assign direct     = (seg == SEG_KDIRECT);
  assign direct_pfn = va[OFF_W +: PFN_W];

  always_comb begin
    if (!span_ok)            early_fault = XF_ADDR;
    else if (direct && user) early_fault = XF_PRIV;
    else                     early_fault = XF_NONE;
  end

  // Level 0 takes the highest index field
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_flat[l*IDX_W +: IDX_W] = va[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

endmodule

// File: rtl/xw_leaf_check.sv
module xw_leaf_check
  import xw_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PFN_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             user,
  input  logic             write,
  output xw_fault_e        fault,
  output logic [PFN_W-1:0] pfn
);

  xw_perm_t perm;

  assign perm  = xw_perm_t'(pte[PTE_FLAG_W-1:0]);
  assign pfn   = pte[PTE_PFN_LSB +: PFN_W];
  assign fault = leaf_verdict(perm, user, write);

endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
  import xw_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int PFN_W  = 32,
  parameter int ENT_SH = 3,
  parameter int PA_W   = PFN_W + IDX_W + ENT_SH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    direct,
  input  xw_fault_e               early_fault,
  input  logic [PFN_W-1:0]        direct_pfn,
  input  logic [LEVELS*IDX_W-1:0] idx_flat,
  input  logic [PFN_W-1:0]        base_pfn,
  input  logic                    rsp_valid,
  input  xw_fault_e               leaf_fault,
  input  logic [PFN_W-1:0]        leaf_pfn,
  output logic                    mem_req,
  output logic [PA_W-1:0]         mem_addr,
  output logic                    resp_valid,
  output logic [PFN_W-1:0]        resp_pfn,
  output xw_fault_e               resp_fault,
  output logic                    busy
);

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int CNT_W = LVL_W + 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  xw_state_e        state;
  logic [LVL_W-1:0] level;
  logic [PFN_W-1:0] cur_pfn;
  logic [IDX_W-1:0] cur_idx;
  logic             res_direct;
  logic [CNT_W-1:0] walk_reads;

  // Named internal events
  logic at_leaf;
  logic entry_absent;

  assign cur_idx      = idx_flat[level*IDX_W +: IDX_W];
  assign at_leaf      = (level == LAST_LVL);
  assign entry_absent = (leaf_fault == XF_ABSENT);

  assign mem_req    = (state == ST_ISSUE);
  assign mem_addr   = {cur_pfn, cur_idx, {ENT_SH{1'b0}}};
  assign resp_valid = (state == ST_DONE);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      level      <= '0;
      cur_pfn    <= '0;
      res_direct <= 1'b0;
      walk_reads <= '0;
      resp_pfn   <= '0;
      resp_fault <= XF_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_DECODE;
            walk_reads <= '0;
            res_direct <= 1'b0;
          end
        end
        ST_DECODE: begin
          if (early_fault != XF_NONE) begin
            state      <= ST_DONE;
            resp_fault <= early_fault;
            resp_pfn   <= '0;
            res_direct <= direct;
          end else if (direct) begin
            state      <= ST_DONE;
            resp_fault <= XF_NONE;
            resp_pfn   <= direct_pfn;
            res_direct <= 1'b1;
          end else begin
            state   <= ST_ISSUE;
            level   <= '0;
            cur_pfn <= base_pfn;
          end
        end
        ST_ISSUE: begin
          state      <= ST_WAIT;
          walk_reads <= walk_reads + CNT_W'(1);
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (entry_absent) begin
              state      <= ST_DONE;
              resp_fault <= XF_ABSENT;
              resp_pfn   <= '0;
            end else if (at_leaf) begin
              state      <= ST_DONE;
              resp_fault <= leaf_fault;
              resp_pfn   <= (leaf_fault == XF_NONE) ? leaf_pfn : '0;
            end else begin
              state   <= ST_ISSUE;
              level   <= level + LVL_W'(1);
              cur_pfn <= leaf_pfn;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_resp_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && !busy));

  p_direct_noread_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && res_direct) |-> (walk_reads == '0));

  p_addr_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == XF_ADDR) |-> (walk_reads == '0));

  p_read_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (walk_reads < CNT_W'(LEVELS)));

  p_absent_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == XF_ABSENT) |-> (walk_reads != '0));

  p_leaf_full_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !res_direct &&
     (resp_fault == XF_NONE || resp_fault == XF_PRIV || resp_fault == XF_PERM))
    |-> (walk_reads == CNT_W'(LEVELS)));

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int LEVELS = 3,
  parameter int PFN_W  = 32,
  parameter int PTE_W  = 64,
  parameter int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_user,
  input  logic             req_write,
  input  logic [PFN_W-1:0] tbl_base_pfn,
  output logic             busy,
  output logic             resp_valid,
  output logic [PFN_W-1:0] resp_pfn,
  output logic [2:0]       resp_fault,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);

  // One table per page: entry size follows from page and index widths
  localparam int ENT_SH = OFF_W - IDX_W;

  logic                    accept;
  logic [VA_W-1:0]         va_q;
  logic                    user_q;
  logic                    write_q;

  xw_seg_e                 seg;
  logic                    direct;
  xw_fault_e               early_fault;
  logic [PFN_W-1:0]        direct_pfn;
  logic [LEVELS*IDX_W-1:0] idx_flat;
  xw_fault_e               leaf_fault;
  logic [PFN_W-1:0]        leaf_pfn;
  xw_fault_e               resp_fault_e;

  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (accept) begin
      va_q    <= req_va;
      user_q  <= req_user;
      write_q <= req_write;
    end
  end

  xw_seg_decode #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .PFN_W(PFN_W)
  ) u_seg (
    .va          (va_q),
    .user        (user_q),
    .seg         (seg),
    .direct      (direct),
    .early_fault (early_fault),
    .direct_pfn  (direct_pfn),
    .idx_flat    (idx_flat)
  );

  xw_leaf_check #(
    .PTE_W(PTE_W), .PFN_W(PFN_W)
  ) u_leaf (
    .pte   (mem_rsp_data),
    .user  (user_q),
    .write (write_q),
    .fault (leaf_fault),
    .pfn   (leaf_pfn)
  );

  xw_walk_ctrl #(
    .IDX_W(IDX_W), .LEVELS(LEVELS), .PFN_W(PFN_W), .ENT_SH(ENT_SH), .PA_W(PA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .direct      (direct),
    .early_fault (early_fault),
    .direct_pfn  (direct_pfn),
    .idx_flat    (idx_flat),
    .base_pfn    (tbl_base_pfn),
    .rsp_valid   (mem_rsp_valid),
    .leaf_fault  (leaf_fault),
    .leaf_pfn    (leaf_pfn),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .resp_valid  (resp_valid),
    .resp_pfn    (resp_pfn),
    .resp_fault  (resp_fault_e),
    .busy        (busy)
  );

  assign resp_fault = resp_fault_e;

  p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(va_q));

  p_seg_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && direct) |-> (seg == SEG_KDIRECT && va_q[VA_W-1] && !va_q[VA_W-2]));

endmodule

// File: tb/xlate_walker_tb_top.sv
`timescale 1ns/1ps
module xlate_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] tbl_base_pfn = 32'h100;
  logic        busy;
  logic        resp_valid;
  logic [31:0] resp_pfn;
  logic [2:0]  resp_fault;
  logic        mem_req;
  logic [44:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_user(req_user), .req_write(req_write), .tbl_base_pfn(tbl_base_pfn),
    .busy(busy), .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_fault(resp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [63:0] memory [longint];
  longint      exp_addr [$];
  bit          m_busy = 0;
  logic [31:0] e_pfn = '0;
  int          e_fault = 0;
  string       e_tag = "";
  string       cur_tag = "";
  int          rsp_cnt = 0;
  int          lat_sel = 0;
  logic [63:0] rsp_hold = '0;

  localparam int FV = 1, FKR = 2, FKW = 4, FUR = 8, FUW = 16;

  function automatic logic [63:0] mkpte(longint pfn, int flags);
    return (64'(pfn) << 32) | 64'(flags);
  endfunction

  task automatic set_pte(longint tbl, int idx, logic [63:0] v);
    memory[tbl * 8192 + longint'(idx) * 8] = v;
  endtask

  function automatic logic [63:0] mkva(int seg, int i1, int i2, int i3);
    return (64'(seg) << 62) | (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'h0a5;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: whole lookup computed at acceptance
  task automatic predict(logic [63:0] va, bit user, bit write);
    longint      tbl;
    longint      addr;
    logic [63:0] e;
    e_pfn = '0;
    exp_addr.delete();
    if (va[63] == 1'b0) begin
      if ((va >> 43) != 0) begin e_fault = 1; return; end
    end else if (va[62] == 1'b1) begin
      if (((va >> 43) & ((64'd1 << 19) - 1)) != 0) begin e_fault = 1; return; end
    end else begin
      if (((va >> 45) & ((64'd1 << 17) - 1)) != 0) begin e_fault = 1; return; end
      if (user) begin e_fault = 3; return; end
      e_fault = 0;
      e_pfn = 32'((va >> 13) & 64'hFFFF_FFFF);
      return;
    end
    tbl = longint'(tbl_base_pfn);
    for (int lv = 0; lv < 3; lv++) begin
      addr = tbl * 8192 + longint'((va >> (33 - 10 * lv)) & 64'd1023) * 8;
      exp_addr.push_back(addr);
      e = memory.exists(addr) ? memory[addr] : 64'd0;
      if (!e[0]) begin e_fault = 2; return; end
      tbl = longint'(e >> 32);
    end
    if (user && !e[3] && !e[4]) e_fault = 3;
    else if (user ? (write ? e[4] : e[3]) : (write ? e[2] : e[1])) begin
      e_fault = 0;
      e_pfn = e[63:32];
    end else e_fault = 4;
  endtask

  // Per-clock memory model and comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_hold;
        end
      end
      if (mem_req) begin
        if (exp_addr.size() == 0) check(1'b0, "R4", "unexpected entry read", longint'(mem_addr), 0);
        else begin
          longint a;
          a = exp_addr.pop_front();
          check(longint'(mem_addr) == a, "R4", "entry address", longint'(mem_addr), a);
        end
        rsp_hold = memory.exists(longint'(mem_addr)) ? memory[longint'(mem_addr)] : 64'd0;
        lat_sel++;
        rsp_cnt = 1 + (lat_sel % 3);
      end
      check(busy == m_busy, "R10", "busy", longint'(busy), longint'(m_busy));
      if (resp_valid) begin
        if (!m_busy) check(1'b0, "R11", "result while idle", 1, 0);
        else begin
          check(int'(resp_fault) == e_fault, e_tag, "fault code", longint'(resp_fault), longint'(e_fault));
          check(resp_pfn == e_pfn, e_tag, "frame", longint'(resp_pfn), longint'(e_pfn));
          check(exp_addr.size() == 0, "R6", "reads still expected", longint'(exp_addr.size()), 0);
          m_busy = 0;
        end
      end else if (req_valid && !m_busy) begin
        predict(req_va, req_user, req_write);
        e_tag = cur_tag;
        m_busy = 1;
      end
    end
  end

  task automatic lookup(logic [63:0] va, bit user, bit write, string tag);
    @(posedge clk); #1;
    req_va = va; req_user = user; req_write = write; req_valid = 1'b1; cur_tag = tag;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait (!m_busy);
  endtask

  // Request held high with other values while the walk runs (R10)
  task automatic lookup_with_noise(logic [63:0] va, logic [63:0] other);
    @(posedge clk); #1;
    req_va = va; req_user = 1'b0; req_write = 1'b0; req_valid = 1'b1; cur_tag = "R10";
    @(posedge clk); #1;
    req_va = other; req_user = 1'b1; req_write = 1'b1;
    repeat (4) @(posedge clk);
    #1 req_valid = 1'b0;
    wait (!m_busy);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    set_pte(32'h100, 5, mkpte(32'h200, FV));
    set_pte(32'h200, 7, mkpte(32'h300, FV));
    set_pte(32'h300, 9, mkpte(32'hABCDE, FV | FKR | FKW | FUR | FUW));
    set_pte(32'h300, 10, mkpte(32'h777, FKR | FUR));
    set_pte(32'h300, 11, mkpte(32'h4411, FV | FKR | FKW));
    set_pte(32'h300, 12, mkpte(32'h5512, FV | FKR | FUR));
    set_pte(32'h300, 13, mkpte(32'hFFFF_FFFF, FV | FUW | 32'h7FE0));

    repeat (3) @(posedge clk);
    #2;
    check(!busy && !resp_valid && !mem_req, "R11", "reset outputs",
          longint'({busy, resp_valid, mem_req}), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Kernel direct segment
    lookup(64'h8000_0000_0000_0000 | (64'h12345 << 13) | 64'h55, 1'b0, 1'b0, "R2");
    lookup(64'h8000_1000_0000_0000, 1'b0, 1'b1, "R2");
    lookup(64'h8000_0000_0000_0000 | (64'h999 << 13), 1'b1, 1'b0, "R2");
    // Malformed addresses
    lookup(64'h8001_0000_0000_0000, 1'b0, 1'b0, "R3");
    lookup(64'h4000_0000_0000_0000 | mkva(0, 5, 7, 9), 1'b0, 1'b0, "R3");
    lookup(mkva(3, 5, 7, 9) | (64'd1 << 50), 1'b0, 1'b0, "R3");
    lookup(mkva(0, 5, 7, 9) | (64'd1 << 43), 1'b1, 1'b0, "R3");
    // Full walks in both user segments
    lookup(mkva(0, 5, 7, 9), 1'b0, 1'b0, "R9");
    lookup(mkva(3, 5, 7, 9), 1'b1, 1'b1, "R1");
    lookup(mkva(0, 5, 7, 9), 1'b1, 1'b0, "R4");
    // Walk ends early
    lookup(mkva(0, 6, 7, 9), 1'b0, 1'b0, "R6");
    lookup(mkva(3, 5, 8, 9), 1'b1, 1'b0, "R6");
    lookup(mkva(0, 5, 7, 10), 1'b0, 1'b0, "R7");
    // Permission cases
    lookup(mkva(0, 5, 7, 11), 1'b1, 1'b0, "R8");
    lookup(mkva(0, 5, 7, 11), 1'b1, 1'b1, "R8");
    lookup(mkva(0, 5, 7, 11), 1'b0, 1'b1, "R9");
    lookup(mkva(0, 5, 7, 12), 1'b1, 1'b1, "R9");
    lookup(mkva(0, 5, 7, 12), 1'b0, 1'b1, "R9");
    lookup(mkva(0, 5, 7, 12), 1'b1, 1'b0, "R9");
    lookup(mkva(0, 5, 7, 13), 1'b1, 1'b1, "R5");
    lookup(mkva(0, 5, 7, 13), 1'b1, 1'b0, "R5");
    lookup(mkva(0, 5, 7, 13), 1'b0, 1'b0, "R5");
    // Ignored requests during a walk
    lookup_with_noise(mkva(0, 5, 7, 9), mkva(0, 6, 1, 1));
    lookup_with_noise(mkva(3, 5, 7, 12), 64'h8000_0000_0000_2000);
    repeat (4) @(posedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule